// File: doc/BRIEF.md
# GF(2) Reduced Row Echelon Engine

This block reduces a binary augmented matrix to reduced row echelon form, with all arithmetic over GF(2). Each row stands for one light and each coefficient column for one button's effect on the lights. The right-hand-side column holds the target light pattern. A caller loads the matrix and its run-time sizes with a one-cycle start strobe. The engine then spends one clock per coefficient column. In that clock it finds a pivot, swaps it into place and clears the column from every other row by XOR. When it finishes, it pulses `done_o`.

The results stay on the outputs until the next accepted start: the reduced matrix, a mask of the pivot columns, the rank and an inconsistency flag. Columns left out of the mask are the free variables that a later solution search iterates over.

Top module: `rref_engine`

## Requirements
- R1: Row i of `mat_i`/`mat_o` occupies bits [i*(COLS_MAX+1) +: COLS_MAX+1]. Bit j of a row is the coefficient of column j, and bit COLS_MAX is the right-hand side. When `done_o` pulses, `mat_o` is the reduced row echelon form of the loaded matrix: every pivot column holds a single 1, in its pivot row, and row addition is bitwise XOR.
- R2: For column c, the pivot is the lowest-numbered row at or below the current pivot row that has a 1 in column c. That row is swapped with the current pivot row before elimination.
- R3: A column with no pivot candidate leaves the matrix unchanged and its bit in `pivot_mask_o` stays 0. Pivot columns have their mask bit set to 1.
- R4: Rows at or above `num_rows_i` and coefficient columns at or above `num_cols_i` are loaded as zero, and they stay zero in the result. Size values above ROWS_MAX or COLS_MAX are treated as the maximum.
- R5: `rank_o` equals the number of pivot columns found.
- R6: `inconsistent_o` is 1 exactly when some row of the result has all-zero coefficients and a 1 in the right-hand side.
- R7: `done_o` is a one-cycle pulse that appears num_cols+1 clock edges after the edge that accepts start (num_cols after clamping). `busy_o` is high from the accepting edge until the edge that raises `done_o`.
- R8: A start strobe that arrives while `busy_o` is high is ignored, and the run in progress completes with its own data.
- R9: After reset all outputs are zero. The results hold unchanged while the engine is idle and no start is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load the matrix and begin reduction (accepted when idle) |
| num_rows_i | input | $clog2(ROWS_MAX+1) | Active number of rows (lights) |
| num_cols_i | input | $clog2(COLS_MAX+1) | Active number of coefficient columns (buttons) |
| mat_i | input | ROWS_MAX*(COLS_MAX+1) | Augmented matrix, packed as in R1 |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mat_o | output | ROWS_MAX*(COLS_MAX+1) | Reduced augmented matrix |
| pivot_mask_o | output | COLS_MAX | Bit j set when column j holds a pivot |
| rank_o | output | $clog2(ROWS_MAX+1) | Number of pivots |
| inconsistent_o | output | 1 | System has no solution |

## Verification
The completion pulse of one run and the acceptance of the next start can fall in the same cycle. This is because the engine is already idle while `done_o` is high. The bench provokes this case by raising start in the very cycle it observes `done_o` after one matrix. It then checks that the second matrix completes with the full expected latency and its own reduced form, mask, rank and flag, with no residue from the first run. A second collision, a start strobe during elimination, is provoked mid-run, and the bench checks that the first result survives intact.

// File: rtl/rref_pkg.sv
// Shared types for the GF(2) reduction engine.
package rref_pkg;
    // Sequencer states: waiting, one column per cycle, result publish.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ELIM = 2'd1,
        ST_FIN  = 2'd2
    } rref_state_e;
endpackage

// File: rtl/rref_pivot_find.sv
// Pivot finder: returns the lowest row index at or above start_row whose
// bit in the current column is set.
// Assumes col_bits already holds the current column, one bit per row.
module rref_pivot_find #(
    parameter int ROWS  = 8,
    parameter int CNT_W = $clog2(ROWS + 1),
    parameter int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic [ROWS-1:0]  col_bits,
    input  logic [CNT_W-1:0] start_row,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Priority search, scanning downwards so the lowest eligible row wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (col_bits[r] && (r >= int'(start_row))) begin
                found = 1'b1;
                idx   = IDX_W'(r);
            end
        end
    end
endmodule

// File: rtl/rref_row_update.sv
// Row update: swaps the pivot row into the current pivot position, then
// XORs the pivot row into every other row with a 1 in the pivot column.
// Assumes piv_idx >= cur_row and that both are valid row indices.
module rref_row_update #(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    parameter int CIX_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [ROWS*(COLS+1)-1:0] mat_in,
    input  logic [IDX_W-1:0]         cur_row,
    input  logic [IDX_W-1:0]         piv_idx,
    input  logic [CIX_W-1:0]         col,
    output logic [ROWS*(COLS+1)-1:0] mat_out
);
    localparam int RW = COLS + 1;

    logic [RW-1:0] rows   [ROWS];
    logic [RW-1:0] piv_row;

    for (genvar g = 0; g < ROWS; g++) begin : g_unpack
        assign rows[g] = mat_in[g*RW +: RW];
    end

    assign piv_row = rows[piv_idx];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        logic [RW-1:0] src;
        logic          hit;
        // Apply the swap for this row position.
        always_comb begin
            if (IDX_W'(g) == cur_row) begin
                src = piv_row;
            end else if (IDX_W'(g) == piv_idx) begin
                src = rows[cur_row];
            end else begin
                src = rows[g];
            end
        end
        // Eliminate the pivot column from every non-pivot row.
        assign hit = (IDX_W'(g) != cur_row) && src[col];
        assign mat_out[g*RW +: RW] = hit ? (src ^ piv_row) : src;
    end
endmodule

// File: rtl/rref_consist_chk.sv
// Consistency check: flags any row whose coefficients are all zero but
// whose right-hand side is 1.
// Assumes unused rows are already zero.
module rref_consist_chk #(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic [ROWS*(COLS+1)-1:0] mat,
    output logic                     bad
);
    localparam int RW = COLS + 1;

    logic [ROWS-1:0] row_bad;

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        assign row_bad[g] = mat[g*RW + COLS] && (mat[g*RW +: COLS] == '0);
    end

    assign bad = |row_bad;
endmodule

// File: rtl/rref_engine.sv
// GF(2) augmented-matrix reducer. On an accepted start, loads the matrix
// with the run-time sizes applied. It then processes one coefficient
// column per clock and publishes the reduced form, the pivot mask, the
// rank and the inconsistency flag with a one-cycle done pulse.
// Assumes the caller holds start for at most the time it wants one run.
// Start is ignored while busy.
module rref_engine #(
    parameter int ROWS_MAX = 8,
    parameter int COLS_MAX = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_i,
    input  logic [$clog2(ROWS_MAX+1)-1:0]       num_rows_i,
    input  logic [$clog2(COLS_MAX+1)-1:0]       num_cols_i,
    input  logic [ROWS_MAX*(COLS_MAX+1)-1:0]    mat_i,
    output logic                                busy_o,
    output logic                                done_o,
    output logic [ROWS_MAX*(COLS_MAX+1)-1:0]    mat_o,
    output logic [COLS_MAX-1:0]                 pivot_mask_o,
    output logic [$clog2(ROWS_MAX+1)-1:0]       rank_o,
    output logic                                inconsistent_o
);
    import rref_pkg::*;

    localparam int RWID  = COLS_MAX + 1;
    localparam int MW    = ROWS_MAX * RWID;
    localparam int CNT_R = $clog2(ROWS_MAX + 1);
    localparam int CNT_C = $clog2(COLS_MAX + 1);
    localparam int IDX_R = (ROWS_MAX > 1) ? $clog2(ROWS_MAX) : 1;
    localparam int IDX_C = (COLS_MAX > 1) ? $clog2(COLS_MAX) : 1;

    rref_state_e          state_q;
    logic [MW-1:0]        mat_q;
    logic [CNT_C-1:0]     ncols_q;
    logic [IDX_C-1:0]     col_q;
    logic [CNT_R-1:0]     prow_q;
    logic [COLS_MAX-1:0]  mask_q;
    logic                 incons_q;
    logic                 done_q;

    logic [CNT_R-1:0]     nrows_eff;
    logic [CNT_C-1:0]     ncols_eff;
    logic [MW-1:0]        load_mat;
    logic [ROWS_MAX-1:0]  col_bits;
    logic                 piv_found;
    logic [IDX_R-1:0]     piv_idx;
    logic [MW-1:0]        upd_mat;
    logic                 incons_w;

    // Clamp the run-time sizes to the built maximums.
    always_comb begin
        nrows_eff = (int'(num_rows_i) > ROWS_MAX) ? CNT_R'(ROWS_MAX) : num_rows_i;
        ncols_eff = (int'(num_cols_i) > COLS_MAX) ? CNT_C'(COLS_MAX) : num_cols_i;
    end

    // Zero every element outside the active rows and columns on load.
    always_comb begin
        load_mat = '0;
        for (int i = 0; i < ROWS_MAX; i++) begin
            if (i < int'(nrows_eff)) begin
                load_mat[i*RWID + COLS_MAX] = mat_i[i*RWID + COLS_MAX];
                for (int j = 0; j < COLS_MAX; j++) begin
                    if (j < int'(ncols_eff)) begin
                        load_mat[i*RWID + j] = mat_i[i*RWID + j];
                    end
                end
            end
        end
    end

    // Gather the current column, one bit per row, for the pivot search.
    always_comb begin
        for (int r = 0; r < ROWS_MAX; r++) begin
            col_bits[r] = mat_q[r*RWID + int'(col_q)];
        end
    end

    rref_pivot_find #(
        .ROWS  (ROWS_MAX),
        .CNT_W (CNT_R),
        .IDX_W (IDX_R)
    ) u_find (
        .col_bits  (col_bits),
        .start_row (prow_q),
        .found     (piv_found),
        .idx       (piv_idx)
    );

    rref_row_update #(
        .ROWS  (ROWS_MAX),
        .COLS  (COLS_MAX),
        .IDX_W (IDX_R),
        .CIX_W (IDX_C)
    ) u_update (
        .mat_in  (mat_q),
        .cur_row (IDX_R'(prow_q)),
        .piv_idx (piv_idx),
        .col     (col_q),
        .mat_out (upd_mat)
    );

    rref_consist_chk #(
        .ROWS (ROWS_MAX),
        .COLS (COLS_MAX)
    ) u_consist (
        .mat (mat_q),
        .bad (incons_w)
    );

    // Sequencer: load, one column per cycle, then publish with done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mat_q    <= '0;
            ncols_q  <= '0;
            col_q    <= '0;
            prow_q   <= '0;
            mask_q   <= '0;
            incons_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mat_q    <= load_mat;
                        ncols_q  <= ncols_eff;
                        col_q    <= '0;
                        prow_q   <= '0;
                        mask_q   <= '0;
                        incons_q <= 1'b0;
                        state_q  <= (ncols_eff == '0) ? ST_FIN : ST_ELIM;
                    end
                end
                ST_ELIM: begin
                    if (piv_found) begin
                        mat_q         <= upd_mat;
                        prow_q        <= prow_q + CNT_R'(1);
                        mask_q[col_q] <= 1'b1;
                    end
                    if (int'(col_q) + 1 >= int'(ncols_q)) begin
                        state_q <= ST_FIN;
                    end else begin
                        col_q <= col_q + IDX_C'(1);
                    end
                end
                ST_FIN: begin
                    incons_q <= incons_w;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o         = (state_q != ST_IDLE);
    assign done_o         = done_q;
    assign mat_o          = mat_q;
    assign pivot_mask_o   = mask_q;
    assign rank_o         = prow_q;
    assign inconsistent_o = incons_q;
endmodule

// File: rtl/rref_engine_chk.sv
// Protocol and result checker for rref_engine, attached by bind.
module rref_engine_chk #(
    parameter int ROWS_MAX = 8,
    parameter int COLS_MAX = 8
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             start_i,
    input logic                             busy_o,
    input logic                             done_o,
    input logic [ROWS_MAX*(COLS_MAX+1)-1:0] mat_o,
    input logic [COLS_MAX-1:0]              pivot_mask_o,
    input logic [$clog2(ROWS_MAX+1)-1:0]    rank_o
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    // R5
    rank_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(rank_o) == $countones(pivot_mask_o)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(mat_o) && $stable(pivot_mask_o) && $stable(rank_o)));
endmodule

bind rref_engine rref_engine_chk #(
    .ROWS_MAX (ROWS_MAX),
    .COLS_MAX (COLS_MAX)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .mat_o        (mat_o),
    .pivot_mask_o (pivot_mask_o),
    .rank_o       (rank_o)
);

// File: tb/rref_engine_tb_top.sv
// Bench for rref_engine with a 4x4 build: a vector table plus directed
// tests for reset, hold, busy-start rejection and back-to-back runs.
module rref_engine_tb_top;
    localparam int R  = 4;
    localparam int C  = 4;
    localparam int MW = R * (C + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [2:0]    num_rows_i = '0;
    logic [2:0]    num_cols_i = '0;
    logic [MW-1:0] mat_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [MW-1:0] mat_o;
    logic [C-1:0]  pivot_mask_o;
    logic [2:0]    rank_o;
    logic          inconsistent_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    rref_engine #(.ROWS_MAX(R), .COLS_MAX(C)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .num_rows_i     (num_rows_i),
        .num_cols_i     (num_cols_i),
        .mat_i          (mat_i),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .mat_o          (mat_o),
        .pivot_mask_o   (pivot_mask_o),
        .rank_o         (rank_o),
        .inconsistent_o (inconsistent_o)
    );

    // Entry: rows(3) cols(3) in(20) out(20) mask(4) rank(3) inconsistent(1)
    // Row 3 is the leftmost 5-bit group; each group is rhs then c3..c0.
    localparam logic [53:0] VECS [8] = '{
        {3'd4, 3'd4, 20'b10100_01000_10001_00010, 20'b01000_10100_00010_10001, 4'b1111, 3'd4, 1'b0},
        {3'd4, 3'd3, 20'b00000_10101_10110_00011, 20'b00000_00000_10110_10101, 4'b0011, 3'd2, 1'b0},
        {3'd3, 3'd3, 20'b00000_10101_00110_00011, 20'b00000_10000_00110_00101, 4'b0011, 3'd2, 1'b1},
        {3'd2, 3'd2, 20'b11111_11111_11011_01110, 20'b00000_00000_00010_10001, 4'b0011, 3'd2, 1'b0},
        {3'd4, 3'd4, 20'b00000_00000_10000_00000, 20'b00000_00000_10000_00000, 4'b0000, 3'd0, 1'b1},
        {3'd2, 3'd0, 20'b00000_00000_00101_10011, 20'b00000_00000_00000_10000, 4'b0000, 3'd0, 1'b1},
        {3'd4, 3'd4, 20'b00001_10111_00000_00000, 20'b00000_00000_10110_00001, 4'b0011, 3'd2, 1'b0},
        {3'd7, 3'd7, 20'b10100_01000_10001_00010, 20'b01000_10100_00010_10001, 4'b1111, 3'd4, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R7 watchdog actual=%0d expected=<20000", cycles);
            finish_run();
        end
    end

    task automatic load(input logic [53:0] v);
        num_rows_i = v[53:51];
        num_cols_i = v[50:48];
        mat_i      = v[47:28];
    endtask

    // Start strobe on a negedge; returns after the accepting edge.
    task automatic pulse_start(input logic [53:0] v);
        load(v);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Counts negedges until done_o is seen.
    task automatic wait_done(output int lat);
        lat = 0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input logic [53:0] v, input string tag);
        check({tag, " R1 R2 matrix"}, 32'(mat_o), 32'(v[27:8]));
        check({tag, " R3 mask"}, 32'(pivot_mask_o), 32'(v[7:4]));
        check({tag, " R5 rank"}, 32'(rank_o), 32'(v[3:1]));
        check({tag, " R6 inconsistent"}, 32'(inconsistent_o), 32'(v[0]));
    endtask

    function automatic int exp_lat(input logic [53:0] v);
        return ((int'(v[50:48]) > C) ? C : int'(v[50:48])) + 1;
    endfunction

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset busy", 32'(busy_o), 0);
        check("R9 reset done", 32'(done_o), 0);
        check("R9 reset matrix", 32'(mat_o), 0);
        check("R9 reset mask", 32'(pivot_mask_o), 0);
        check("R9 reset rank", 32'(rank_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk; entries 3 and 7 exercise R4 sizing and clamping.
        for (int k = 0; k < 8; k++) begin
            pulse_start(VECS[k]);
            check($sformatf("R7 busy vec%0d", k), 32'(busy_o), 1);
            wait_done(lat);
            check($sformatf("R7 latency vec%0d", k), 32'(lat), 32'(exp_lat(VECS[k])));
            check_result(VECS[k], $sformatf("vec%0d%s", k, (k == 3 || k == 7) ? " R4" : ""));
            @(negedge clk);
            check($sformatf("R7 done width vec%0d", k), 32'(done_o), 0);
        end

        // R9 hold: results unchanged while idle without start.
        repeat (5) @(negedge clk);
        check("R9 hold matrix", 32'(mat_o), 32'(VECS[7][27:8]));
        check("R9 hold mask", 32'(pivot_mask_o), 32'(VECS[7][7:4]));

        // R8 start while busy is ignored.
        pulse_start(VECS[0]);
        load(VECS[4]);
        start_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 2;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R8 latency", 32'(lat), 32'(exp_lat(VECS[0])));
        check_result(VECS[0], "R8 busy start");
        @(negedge clk);
        check("R8 no second run", 32'(busy_o), 0);

        // Start raised in the same cycle done is seen (back-to-back).
        pulse_start(VECS[1]);
        wait_done(lat);
        check_result(VECS[1], "R7 first of pair");
        pulse_start(VECS[6]);
        wait_done(lat);
        check("R7 back-to-back latency", 32'(lat), 32'(exp_lat(VECS[6])));
        check_result(VECS[6], "R7 second of pair");

        finish_run();
    end
endmodule